// File: doc/BRIEF.md
# Token-Tagged Dataflow Compute Node

This block is one processing element of a reconfigurable dataflow fabric. Each word arriving on an input port is paired with a 2-bit control token. The node applies one operation, chosen in a small configuration register, and places the result together with a token in a single output register. Nothing outside the node tells it when to run. It fires only when every input it needs is valid and its output register is either empty or being emptied in the same cycle.

The token carries stream structure beside the data. The node decodes it locally. In accumulate mode an end-of-stream token makes the node release its running sum and start again from zero. Every other token is copied to the output next to the computed value. In the two-input operations the two incoming tokens are merged. When they disagree, the node raises an error flag on that result, and end of stream takes priority.

A node is placed between neighbouring nodes. Its output handshake feeds a downstream input, and its operation is written once through the configuration port before streaming begins.

Top module: `dfNode`

## Requirements
- R1: After reset `outValid` is 0, the accumulator holds 0 and the operation is pass-through.
- R2: A word is consumed (`aRdy`, and for two-input operations also `bRdy`, high in a cycle) only when `aValid` is high, `bValid` is also high for two-input operations, and either `outValid` is 0 or `outRdy` is 1.
- R3: While `outValid` is 1 and `outRdy` is 0, `outValid`, `outData`, `outTok` and `outErr` keep their values.
- R4: When `cfgWe` is high, `cfgOp` is loaded into the configuration register. The codes are 00 pass-through (result = A), 01 add (A+B modulo 2^DATA_W), 10 multiply (low DATA_W bits of A*B) and 11 accumulate.
- R5: In pass-through and accumulate the B port is ignored: `bRdy` stays 0 and B data and tokens do not affect the output.
- R6: In accumulate mode a consumed word whose token is not end of stream adds its data to the accumulator and produces no output. A consumed end-of-stream word produces the output accumulator + data, tagged end of stream, and leaves the accumulator at 0.
- R7: Token codes are 00 data, 01 end of stream, 10 start of frame and 11 user control. In the non-accumulating operations, a token equal on all used inputs is copied to `outTok` unchanged, and `outErr` is 0.
- R8: In add and multiply, if `aTok` and `bTok` differ, `outErr` is 1 for that result. `outTok` is end of stream if either input carries it, and otherwise `aTok`.
- R9: A result that is produced appears on `outValid`/`outData` in the cycle after the one in which its inputs are consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgOp | input | 2 | Operation code to load |
| aValid | input | 1 | Port A word available |
| aRdy | output | 1 | Port A word consumed this cycle |
| aData | input | DATA_W | Port A data |
| aTok | input | 2 | Port A token |
| bValid | input | 1 | Port B word available |
| bRdy | output | 1 | Port B word consumed this cycle |
| bData | input | DATA_W | Port B data |
| bTok | input | 2 | Port B token |
| outValid | output | 1 | Output register holds a result |
| outRdy | input | 1 | Downstream takes the result this cycle |
| outData | output | DATA_W | Result data |
| outTok | output | 2 | Result token |
| outErr | output | 1 | Token mismatch on the inputs of this result |

## Verification
The draining of a held result and the consumption of the next input word can happen in the same cycle. This shows whether the output register really frees one slot per cycle without losing or duplicating a word. The bench stalls the output with `outRdy` low, presents a second word, and confirms that it is refused and that the held result stays unchanged. It then raises `outRdy` while that word is still offered and checks that, one edge later, the register holds the second result and the first was delivered. A second collision is checked on its own: an end-of-stream token meeting a different token on the other port in the same consumption, where the merged token and the error flag are both judged on that single output word.

// File: rtl/dfNodePkg.sv
package dfNodePkg;

  typedef enum logic [1:0] {
    TK_DATA = 2'b00,
    TK_EOS  = 2'b01,
    TK_SOF  = 2'b10,
    TK_USER = 2'b11
  } tok_e;

  typedef enum logic [1:0] {
    OP_PASS = 2'b00,
    OP_ADD  = 2'b01,
    OP_MUL  = 2'b10,
    OP_ACC  = 2'b11
  } op_e;

  typedef struct packed {
    logic load;    // capture result into output register
    logic accAdd;  // add port A into accumulator
    logic accClr;  // clear accumulator
    tok_e tok;     // merged token for this result
    logic err;     // token mismatch
  } strobes_t;

  function automatic logic isDual(op_e op);
    return (op == OP_ADD) || (op == OP_MUL);
  endfunction

endpackage

// File: rtl/dfNodeCtrl.sv
module dfNodeCtrl
  import dfNodePkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  op_e      op,
  input  logic     aValid,
  input  tok_e     aTok,
  input  logic     bValid,
  input  tok_e     bTok,
  input  logic     outRdy,
  output logic     aRdy,
  output logic     bRdy,
  output logic     outValid,
  output strobes_t stb
);

  logic dual;
  logic fire;
  logic eosHit;
  tok_e mergedTok;
  logic mismatch;

  assign dual = isDual(op);
  assign fire = aValid && (!dual || bValid) && (!outValid || outRdy);
  assign aRdy = fire;
  assign bRdy = fire && dual;

  // Local token decode: end of stream wins on disagreement.
  always_comb begin
    mismatch  = dual && (aTok != bTok);
    mergedTok = aTok;
    if (dual && (bTok == TK_EOS)) mergedTok = TK_EOS;
  end

  assign eosHit = (mergedTok == TK_EOS);

  always_comb begin
    stb.tok    = mergedTok;
    stb.err    = mismatch;
    stb.accAdd = 1'b0;
    stb.accClr = 1'b0;
    if (op == OP_ACC) begin
      stb.load   = fire && eosHit;
      stb.accAdd = fire && !eosHit;
      stb.accClr = fire && eosHit;
    end else begin
      stb.load = fire;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         outValid <= 1'b0;
    else if (stb.load) outValid <= 1'b1;
    else if (outRdy)   outValid <= 1'b0;
  end

endmodule

// File: rtl/dfNodeDp.sv
module dfNodeDp
  import dfNodePkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  op_e               cfgIn,
  output op_e               op,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] bData,
  input  strobes_t          stb,
  output logic [DATA_W-1:0] outData,
  output tok_e              outTok,
  output logic              outErr
);

  logic [DATA_W-1:0] accQ;
  logic [DATA_W-1:0] result;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      op <= OP_PASS;
    else if (cfgWe) op <= cfgIn;
  end

  always_comb begin
    case (op)
      OP_ADD:  result = aData + bData;
      OP_MUL:  result = aData * bData;
      OP_ACC:  result = accQ + aData;
      default: result = aData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           accQ <= '0;
    else if (stb.accClr) accQ <= '0;
    else if (stb.accAdd) accQ <= accQ + aData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outTok  <= TK_DATA;
      outErr  <= 1'b0;
    end else if (stb.load) begin
      outData <= result;
      outTok  <= stb.tok;
      outErr  <= stb.err;
    end
  end

endmodule

// File: rtl/dfNode.sv
module dfNode
  import dfNodePkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgOp,
  input  logic              aValid,
  output logic              aRdy,
  input  logic [DATA_W-1:0] aData,
  input  logic [1:0]        aTok,
  input  logic              bValid,
  output logic              bRdy,
  input  logic [DATA_W-1:0] bData,
  input  logic [1:0]        bTok,
  output logic              outValid,
  input  logic              outRdy,
  output logic [DATA_W-1:0] outData,
  output logic [1:0]        outTok,
  output logic              outErr
);

  strobes_t stb;
  op_e      curOp;
  tok_e     outTokE;

  dfNodeCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .op      (curOp),
    .aValid  (aValid),
    .aTok    (tok_e'(aTok)),
    .bValid  (bValid),
    .bTok    (tok_e'(bTok)),
    .outRdy  (outRdy),
    .aRdy    (aRdy),
    .bRdy    (bRdy),
    .outValid(outValid),
    .stb     (stb)
  );

  dfNodeDp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfgWe  (cfgWe),
    .cfgIn  (op_e'(cfgOp)),
    .op     (curOp),
    .aData  (aData),
    .bData  (bData),
    .stb    (stb),
    .outData(outData),
    .outTok (outTokE),
    .outErr (outErr)
  );

  assign outTok = outTokE;

endmodule

// File: rtl/dfNodeChk.sv
module dfNodeChk
  import dfNodePkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input op_e               curOp,
  input logic              aValid,
  input logic              aRdy,
  input logic [1:0]        aTok,
  input logic [1:0]        bTok,
  input logic              bRdy,
  input logic              outValid,
  input logic              outRdy,
  input logic [DATA_W-1:0] outData,
  input logic [1:0]        outTok,
  input logic              outErr
);

  logic takeA;
  assign takeA = aValid && aRdy;

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outRdy) |=> (outValid && $stable(outData) && $stable(outTok) && $stable(outErr)));

  // R2
  no_accept_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outRdy) |-> !aRdy);

  // R5
  single_no_b_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((curOp == OP_PASS) || (curOp == OP_ACC)) |-> !bRdy);

  // R6
  acc_eos_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeA && (curOp == OP_ACC) && (aTok == 2'b01)) |=> (outValid && (outTok == 2'b01)));

  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeA && (curOp != OP_ACC)) |=> outValid);

  // R8
  eos_priority_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bRdy && ((aTok == 2'b01) || (bTok == 2'b01))) |=> (outTok == 2'b01));

endmodule

bind dfNode dfNodeChk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .curOp   (curOp),
  .aValid  (aValid),
  .aRdy    (aRdy),
  .aTok    (aTok),
  .bTok    (bTok),
  .bRdy    (bRdy),
  .outValid(outValid),
  .outRdy  (outRdy),
  .outData (outData),
  .outTok  (outTok),
  .outErr  (outErr)
);

// File: tb/dfNode_tb.sv
`timescale 1ns/1ps
module dfNode_tb;

  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWe = 1'b0;
  logic [1:0]    cfgOp = 2'b00;
  logic          aValid = 1'b0, bValid = 1'b0, outRdy = 1'b1;
  logic [DW-1:0] aData = '0, bData = '0;
  logic [1:0]    aTok = 2'b00, bTok = 2'b00;
  logic          aRdy, bRdy, outValid, outErr;
  logic [DW-1:0] outData;
  logic [1:0]    outTok;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dfNode #(.DATA_W(DW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgOp(cfgOp),
    .aValid(aValid), .aRdy(aRdy), .aData(aData), .aTok(aTok),
    .bValid(bValid), .bRdy(bRdy), .bData(bData), .bTok(bTok),
    .outValid(outValid), .outRdy(outRdy), .outData(outData),
    .outTok(outTok), .outErr(outErr)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic setOp(input logic [1:0] op);
    @(negedge clk);
    cfgWe = 1'b1; cfgOp = op;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  // Offer one word (and B if useB), wait for consumption, return at edge+1.
  task automatic push(input logic [DW-1:0] a, input logic [1:0] ta,
                      input bit useB, input logic [DW-1:0] b, input logic [1:0] tb);
    @(negedge clk);
    aValid = 1'b1; aData = a; aTok = ta;
    bValid = useB; bData = b; bTok = tb;
    #0.5;
    while (!aRdy) begin
      @(negedge clk); #0.5;
    end
    @(posedge clk); #1;
  endtask

  task automatic idle();
    @(negedge clk);
    aValid = 1'b0; bValid = 1'b0;
  endtask

  task automatic expectOut(input string req, input logic [DW-1:0] d,
                           input logic [1:0] t, input logic e);
    check(outValid === 1'b1, req, outValid, 1);
    check(outData === d, req, outData, d);
    check(outTok === t, req, outTok, t);
    check(outErr === e, req, outErr, e);
  endtask

  task automatic tReset();
    check(outValid === 1'b0, "R1 outValid", outValid, 0);
    check(aRdy === 1'b0, "R1 aRdy idle", aRdy, 0);
  endtask

  task automatic tPass();
    // R4 pass-through, R7 tokens copied, R5 B ignored
    push(16'h1234, 2'b00, 1'b1, 16'hFFFF, 2'b01);
    check(bRdy === 1'b0, "R5 bRdy in pass", bRdy, 0);
    expectOut("R4 pass data", 16'h1234, 2'b00, 1'b0);
    push(16'h00AA, 2'b10, 1'b1, 16'h0001, 2'b11);
    expectOut("R7 SOF copied", 16'h00AA, 2'b10, 1'b0);
    push(16'h0BEE, 2'b11, 1'b0, 16'h0, 2'b00);
    expectOut("R7 user copied", 16'h0BEE, 2'b11, 1'b0);
    idle();
  endtask

  task automatic tAddMul();
    setOp(2'b01);
    // R2: only A valid must not fire in add
    @(negedge clk);
    aValid = 1'b1; aData = 16'd5; aTok = 2'b00; bValid = 1'b0;
    #0.5;
    check(aRdy === 1'b0, "R2 add waits for B", aRdy, 0);
    push(16'hFFF0, 2'b00, 1'b1, 16'h0020, 2'b00);
    expectOut("R4 add wrap", 16'h0010, 2'b00, 1'b0);
    push(16'd300, 2'b10, 1'b1, 16'd45, 2'b10);
    expectOut("R9 add SOF", 16'd345, 2'b10, 1'b0);
    idle();
    setOp(2'b10);
    push(16'h0100, 2'b00, 1'b1, 16'h0123, 2'b00);
    expectOut("R4 mul low bits", 16'h2300, 2'b00, 1'b0);
    push(16'd7, 2'b11, 1'b1, 16'd9, 2'b11);
    expectOut("R7 mul user", 16'd63, 2'b11, 1'b0);
    idle();
  endtask

  task automatic tMismatch();
    setOp(2'b01);
    push(16'd1, 2'b10, 1'b1, 16'd2, 2'b01);
    expectOut("R8 B eos wins", 16'd3, 2'b01, 1'b1);
    push(16'd4, 2'b01, 1'b1, 16'd4, 2'b11);
    expectOut("R8 A eos wins", 16'd8, 2'b01, 1'b1);
    push(16'd10, 2'b10, 1'b1, 16'd1, 2'b11);
    expectOut("R8 A token kept", 16'd11, 2'b10, 1'b1);
    push(16'd10, 2'b01, 1'b1, 16'd1, 2'b01);
    expectOut("R7 both eos no err", 16'd11, 2'b01, 1'b0);
    idle();
  endtask

  task automatic tAcc();
    setOp(2'b11);
    push(16'd10, 2'b10, 1'b1, 16'd999, 2'b01);
    check(outValid === 1'b0, "R6 no out mid-stream", outValid, 0);
    check(bRdy === 1'b0, "R5 bRdy in acc", bRdy, 0);
    push(16'd20, 2'b00, 1'b0, 16'd0, 2'b00);
    push(16'd30, 2'b11, 1'b0, 16'd0, 2'b00);
    check(outValid === 1'b0, "R6 no out on user tok", outValid, 0);
    push(16'd5, 2'b01, 1'b0, 16'd0, 2'b00);
    expectOut("R6 acc sum eos", 16'd65, 2'b01, 1'b0);
    // second stream starts from zero
    push(16'd3, 2'b00, 1'b0, 16'd0, 2'b00);
    push(16'd4, 2'b01, 1'b0, 16'd0, 2'b00);
    expectOut("R6 acc cleared", 16'd7, 2'b01, 1'b0);
    // single-word stream
    push(16'd9, 2'b01, 1'b0, 16'd0, 2'b00);
    expectOut("R6 single eos", 16'd9, 2'b01, 1'b0);
    idle();
    @(posedge clk); #1;
    check(outValid === 1'b0, "R9 drained", outValid, 0);
  endtask

  task automatic tStall();
    setOp(2'b00);
    @(negedge clk);
    outRdy = 1'b0;
    push(16'h0A0A, 2'b10, 1'b0, 16'd0, 2'b00);
    expectOut("R9 first word", 16'h0A0A, 2'b10, 1'b0);
    @(negedge clk);
    aValid = 1'b1; aData = 16'h0B0B; aTok = 2'b00;
    #0.5;
    check(aRdy === 1'b0, "R2 refuse when full", aRdy, 0);
    @(posedge clk); #1;
    @(posedge clk); #1;
    expectOut("R3 held stable", 16'h0A0A, 2'b10, 1'b0);
    @(negedge clk);
    outRdy = 1'b1;
    #0.5;
    check(aRdy === 1'b1, "R2 accept while draining", aRdy, 1);
    @(posedge clk); #1;
    expectOut("R2 replaced same cycle", 16'h0B0B, 2'b00, 1'b0);
    idle();
    @(posedge clk); #1;
    check(outValid === 1'b0, "R3 released", outValid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    tReset();
    @(negedge clk);
    rstN = 1'b1;
    tPass();
    tAddMul();
    tMismatch();
    tAcc();
    tStall();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule